// File: doc/BRIEF.md
# Floppy Disk Transfer Buffer with DMA Handshake

This block carries the data bytes of a floppy controller's data command during the execution phase. It sits between the host or DMA side, which moves bytes with an active-low acknowledge strobe and no address, and the serial disk side, which offers read bytes or asks for write bytes one at a time. A small byte FIFO absorbs the rate difference. A programmable threshold decides when the block raises its DMA request.

A command starts with a one-cycle `cmd_start` pulse. That pulse captures the direction and mode, empties the FIFO and clears the error flags. On a write, the disk side takes each sector as `SECTOR_BYTES` data bytes followed by two CRC-16 bytes. On a read, the disk side supplies the data bytes and the host drains them. If either side runs dry or floods the FIFO, the command ends. An aborted write still finishes its sector with zero bytes and a correct CRC. An aborted read waits until the host has emptied the FIFO. A terminal-count input ends the command cleanly at the next sector boundary. A byte mode cuts the FIFO down to a single byte. Within byte mode, a verify variant lets the acknowledge strobe discard read bytes without presenting them.

Top module: `fdc_xfer_path`

## Requirements
- R1: Outside a command, `busy`, `drq` and `done` are low, and acknowledge strobes leave nothing in the FIFO. `done` is high for exactly one cycle at the end of each command.
- R2: A `cmd_start` pulse empties the FIFO and clears `overrun` and `underrun`. No byte from before the pulse can be read afterwards.
- R3: On a write, the disk side receives the host's bytes in order. After every `SECTOR_BYTES` data bytes come two CRC bytes, high byte first. The CRC is CRC-16 with polynomial 0x1021, is fed MSB first, and is preset to 0xFFFF at the start of each sector.
- R4: On a read, the host receives the disk bytes in arrival order on `host_rdata`, and one byte is consumed for each cycle in which `dma_ack_n` is low.
- R5: With the FIFO enabled, a read raises `drq` only while the fill level exceeds `cfg_thresh`. A write raises `drq` while the fill level is at most `cfg_thresh` and the FIFO is not full. `drq` needs `cfg_dma_en`.
- R6: A `term_count` pulse during a command ends it at the next sector boundary with no error flag. A write ends after the sector's CRC, and a read ends once the FIFO is empty.
- R7: On a write, a disk byte request that finds the FIFO empty sets `underrun`. That byte and every remaining byte of the sector go out as 0x00, followed by the CRC of the sector as sent. The command then ends, and `drq` stays low from the error onward.
- R8: On a write, a host strobe that finds the FIFO full drops its byte and sets `overrun`. The rest of the current sector, including any bytes still buffered, then goes out as 0x00 with a valid CRC, and the command ends.
- R9: On a read, a disk byte that finds the FIFO full is dropped and sets `overrun`. The host can still drain the buffered bytes in order, and `done` follows only after the FIFO is empty.
- R10: On a read, a host strobe that finds the FIFO empty sets `underrun`, and the command ends.
- R11: When `cfg_fifo_en` is low at `cmd_start`, the FIFO holds one byte. A second disk byte before a host strobe is an overrun, and `drq` on a read means one byte is waiting.
- R12: In byte mode on a read with `cfg_verify` high, each host strobe removes a byte while `host_rdata` stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse that opens the execution phase |
| cmd_write | input | 1 | Direction captured at start: 1 = write to disk |
| cfg_fifo_en | input | 1 | 1 = FIFO of DEPTH bytes, 0 = single-byte mode |
| cfg_dma_en | input | 1 | Enables the DMA request |
| cfg_verify | input | 1 | Verify pseudo-read, used in byte-mode reads |
| cfg_thresh | input | $clog2(DEPTH) | DMA request threshold |
| dma_ack_n | input | 1 | Active-low host strobe, one byte per low cycle |
| host_wdata | input | 8 | Byte from the host on a write |
| host_rdata | output | 8 | Byte for the host on a read (FIFO head) |
| drq | output | 1 | DMA request |
| dsk_rx_valid | input | 1 | Disk side offers a read byte this cycle |
| dsk_rx_data | input | 8 | Read byte from the disk side |
| dsk_tx_req | input | 1 | Disk side takes a write byte this cycle |
| dsk_tx_data | output | 8 | Write byte for the disk side |
| term_count | input | 1 | Terminal count pulse |
| busy | output | 1 | Command in progress |
| overrun | output | 1 | Overrun seen during this command |
| underrun | output | 1 | Underrun seen during this command |
| done | output | 1 | One-cycle pulse when the command ends |

## Verification
A normal write and a normal read each run two sectors with random byte values, random disk pacing and a host that answers the request. These runs show the data order, the CRC placement and the threshold-driven handshake working together with a terminal-count ending. The directed aborts starve the FIFO after a few bytes, overflow it from the host, and flood it from the disk. Their streams differ only in where the zero fill starts and in which CRC follows, so a wrong fill start or a CRC seeded wrongly shows up as a byte mismatch. Byte-mode and verify cases, plus a restart in the middle of a command, separate the one-byte capacity, the pseudo-read and the flush from normal FIFO behaviour.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_XFER, ST_PAD, ST_CRC, ST_DRAIN, ST_DONE
  } fxp_state_e;

  // One byte into CRC-16 (poly 0x1021), one bit at a time, MSB first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction
endpackage

// File: rtl/fxp_fifo.sv
module fxp_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [7:0]   wdata,
  input  logic         pop,
  output logic [7:0]   head,
  output logic [AW:0]  count
);
  logic [7:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign head = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == (AW+1)'(DEPTH) && !pop) |-> !push);  // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !pop);  // R10
endmodule

// File: rtl/fxp_crc.sv
module fxp_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import fxp_pkg::*;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= 16'hFFFF;
    else if (clear) crc <= 16'hFFFF;
    else if (en)    crc <= crc16_byte(crc, din);
  end
endmodule

// File: rtl/fdc_xfer_path.sv
module fdc_xfer_path #(
  parameter int DEPTH        = 16,
  parameter int SECTOR_BYTES = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(SECTOR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_write,
  input  logic          cfg_fifo_en,
  input  logic          cfg_dma_en,
  input  logic          cfg_verify,
  input  logic [AW-1:0] cfg_thresh,
  input  logic          dma_ack_n,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          drq,
  input  logic          dsk_rx_valid,
  input  logic [7:0]    dsk_rx_data,
  input  logic          dsk_tx_req,
  output logic [7:0]    dsk_tx_data,
  input  logic          term_count,
  output logic          busy,
  output logic          overrun,
  output logic          underrun,
  output logic          done
);
  import fxp_pkg::*;

  fxp_state_e    state, nxt;
  logic          m_wr, m_fen, m_ver;
  logic [AW-1:0] m_thr;
  logic          tc_seen, crc_idx;
  logic [SW-1:0] sec_cnt;
  logic [AW:0]   fcnt;
  logic [7:0]    head, tx_byte;
  logic [15:0]   crc;

  // Named internal events
  logic full_eff, empty, host_acc, wr_x, rd_x, rd_act;
  logic ev_push, ev_pop, ev_ovr, ev_udr, crc_en, crc_clr, sec_step, sec_last, crc_end, term;

  assign full_eff = m_fen ? (fcnt == (AW+1)'(DEPTH)) : (fcnt != '0);
  assign empty    = (fcnt == '0);
  assign host_acc = !dma_ack_n;
  assign wr_x     = (state == ST_XFER) && m_wr;
  assign rd_x     = (state == ST_XFER) && !m_wr;
  assign rd_act   = !m_wr && (state == ST_XFER || state == ST_DRAIN);

  assign ev_push  = (wr_x && host_acc && !full_eff) || (rd_x && dsk_rx_valid && !full_eff);
  assign ev_pop   = (wr_x && dsk_tx_req && !empty) || (rd_act && host_acc && !empty);
  assign ev_ovr   = (wr_x && host_acc && full_eff) || (rd_x && dsk_rx_valid && full_eff);
  assign ev_udr   = (wr_x && dsk_tx_req && empty) || (rd_x && host_acc && empty);

  assign crc_en   = m_wr && dsk_tx_req && (state == ST_XFER || state == ST_PAD);
  assign crc_end  = (state == ST_CRC) && dsk_tx_req && crc_idx;
  assign crc_clr  = cmd_start || crc_end;
  assign sec_step = crc_en || (rd_x && dsk_rx_valid && !full_eff);
  assign sec_last = sec_step && (sec_cnt == SW'(SECTOR_BYTES - 1));
  assign term     = tc_seen || term_count || overrun || underrun;

  always_comb begin
    case (state)
      ST_XFER: tx_byte = empty ? 8'h00 : head;
      ST_CRC:  tx_byte = crc_idx ? crc[7:0] : crc[15:8];
      default: tx_byte = 8'h00;
    endcase
  end
  assign dsk_tx_data = m_wr ? tx_byte : 8'h00;
  assign host_rdata  = (!m_wr && !m_ver) ? head : 8'h00;

  always_comb begin
    drq = 1'b0;
    if (cfg_dma_en) begin
      if (wr_x)                  drq = !full_eff && (fcnt <= (AW+1)'(m_thr));
      else if (rd_x)             drq = m_fen ? (fcnt > (AW+1)'(m_thr)) : !empty;
      else if (state == ST_DRAIN) drq = !empty;
    end
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  nxt = ST_IDLE;
      ST_XFER:
        if (m_wr) begin
          if (sec_last)              nxt = ST_CRC;
          else if (ev_ovr || ev_udr) nxt = ST_PAD;
        end else if (ev_ovr || ev_udr || (sec_last && (tc_seen || term_count))) begin
          nxt = ST_DRAIN;
        end
      ST_PAD:   if (sec_last) nxt = ST_CRC;
      ST_CRC:   if (crc_end) nxt = term ? ST_DONE : ST_XFER;
      ST_DRAIN: if (empty) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (cmd_start) nxt = ST_XFER;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; m_wr <= 1'b0; m_fen <= 1'b1; m_ver <= 1'b0; m_thr <= '0;
      tc_seen <= 1'b0; crc_idx <= 1'b0; sec_cnt <= '0; overrun <= 1'b0; underrun <= 1'b0;
    end else begin
      state <= nxt;
      if (cmd_start) begin
        m_wr <= cmd_write; m_fen <= cfg_fifo_en; m_ver <= cfg_verify; m_thr <= cfg_thresh;
        tc_seen <= 1'b0; crc_idx <= 1'b0; sec_cnt <= '0; overrun <= 1'b0; underrun <= 1'b0;
      end else begin
        if (busy && term_count) tc_seen <= 1'b1;
        if (ev_ovr) overrun <= 1'b1;
        if (ev_udr) underrun <= 1'b1;
        if (state == ST_CRC && dsk_tx_req) crc_idx <= !crc_idx;
        if (sec_last)      sec_cnt <= '0;
        else if (sec_step) sec_cnt <= sec_cnt + 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  fxp_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(cmd_start),
    .push(ev_push), .wdata(m_wr ? host_wdata : dsk_rx_data),
    .pop(ev_pop), .head(head), .count(fcnt)
  );

  fxp_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clr), .en(crc_en),
    .din(tx_byte), .crc(crc)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drq);  // R1
  AST_FLUSH_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (fcnt == '0));  // R2
  AST_CRC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CRC && dsk_tx_req && !crc_idx && !cmd_start) |=> (state == ST_CRC));  // R3
  AST_ABORT_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && m_wr && (overrun || underrun)) |-> !drq);  // R7
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !m_wr) |-> (fcnt == '0));  // R9
endmodule

// File: tb/sim_fdc_xfer_path.sv
`timescale 1ns/1ps
module sim_fdc_xfer_path;
  localparam int SB = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_write = 0, cfg_fifo_en = 1, cfg_dma_en = 1, cfg_verify = 0;
  logic [3:0] cfg_thresh = 0;
  logic dma_ack_n = 1, dsk_rx_valid = 0, dsk_tx_req = 0, term_count = 0;
  logic [7:0] host_wdata = 0, dsk_rx_data = 0;
  logic [7:0] host_rdata, dsk_tx_data;
  logic drq, busy, overrun, underrun, done;
  int checks = 0, errors = 0;
  logic [7:0] ex [0:63];
  logic [7:0] dq [0:63];

  always #4 clk = ~clk;

  fdc_xfer_path #(.DEPTH(16), .SECTOR_BYTES(SB)) u0 (.*);

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0h expected %0h", req, act, exp); end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic start(input logic w, input logic fen, input logic ver, input logic [3:0] th);
    cmd_start = 1; cmd_write = w; cfg_fifo_en = fen; cfg_verify = ver; cfg_thresh = th;
    step(); cmd_start = 0;
  endtask

  // fill ex[0..SB+1]: first nd bytes from dq, rest zero, then CRC high/low
  task automatic build_sector(input int nd);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < SB; i++) begin
      ex[i] = (i < nd) ? dq[i] : 8'h00;
      c = ref_crc(c, ex[i]);
    end
    ex[SB] = c[15:8]; ex[SB+1] = c[7:0];
  endtask

  task automatic pull(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(); dsk_tx_req = 1;
      chk(dsk_tx_data == ex[i], req, dsk_tx_data, ex[i]);
    end
    step(); dsk_tx_req = 0;
  endtask

  task automatic wait_done(input string req);
    logic seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      if (done) seen = 1; else step();
    end
    chk(seen, req, seen, 1);
    step();
    chk(!busy && !done, req, {busy, done}, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++; $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) step();
    rst_n = 1; step();
    // R1: reset state and strobes outside a command
    chk(!drq && !busy && !done, "R1", {drq, busy, done}, 0);
    dma_ack_n = 0; step(); dma_ack_n = 1;
    chk(!drq && !busy, "R1", {drq, busy}, 0);

    // R2: restart in mid-command discards buffered bytes
    start(0, 1, 0, 4'd0);
    for (int i = 0; i < 3; i++) begin dsk_rx_valid = 1; dsk_rx_data = 8'h30 + 8'(i); step(); end
    dsk_rx_valid = 0;
    start(0, 1, 0, 4'd0);
    chk(!drq, "R2", drq, 0);
    dma_ack_n = 0; step(); dma_ack_n = 1;
    chk(underrun, "R2", underrun, 1);
    wait_done("R10");
    start(0, 1, 0, 4'd0);
    chk(!underrun && !overrun, "R2", {overrun, underrun}, 0);
    start(1, 1, 0, 4'd0); // leave it pending; next start restarts again

    // R3 R5 R6: normal write, two sectors, terminal count in second
    for (int i = 0; i < 2 * SB; i++) dq[i] = 8'($urandom);
    begin
      logic [15:0] c; int k = 0;
      for (int s = 0; s < 2; s++) begin
        c = 16'hFFFF;
        for (int i = 0; i < SB; i++) begin ex[k] = dq[s*SB+i]; c = ref_crc(c, ex[k]); k++; end
        ex[k] = c[15:8]; ex[k+1] = c[7:0]; k += 2;
      end
    end
    start(1, 1, 0, 4'd6);
    begin
      int hi = 0, ti = 0, n = 0; logic tcd = 0; logic seen = 0;
      while (n < 2000 && !seen) begin
        step();
        dma_ack_n = 1; dsk_tx_req = 0; term_count = 0;
        if (done) seen = 1;
        else begin
          if (drq && hi < 2 * SB) begin dma_ack_n = 0; host_wdata = dq[hi]; hi++; end
          if (n > 20 && ti < 2 * SB + 4 && ($urandom % 3) == 0) begin
            dsk_tx_req = 1;
            chk(dsk_tx_data == ex[ti], "R3", dsk_tx_data, ex[ti]);
            ti++;
          end
          if (ti == 20 && !tcd) begin term_count = 1; tcd = 1; end
          n++;
        end
      end
      chk(seen && ti == 2 * SB + 4, "R6", ti, 2 * SB + 4);
      chk(!overrun && !underrun, "R6", {overrun, underrun}, 0);
    end
    step();

    // R5: write request threshold
    start(1, 1, 0, 4'd2);
    chk(drq, "R5", drq, 1);
    for (int i = 0; i < 3; i++) begin dma_ack_n = 0; host_wdata = 8'h11; step(); end
    dma_ack_n = 1;
    chk(!drq, "R5", drq, 0);
    cfg_dma_en = 0; start(1, 1, 0, 4'd2);
    chk(!drq, "R5", drq, 0);
    cfg_dma_en = 1;

    // R7: write underrun after 5 bytes
    start(1, 1, 0, 4'd8);
    for (int i = 0; i < 5; i++) begin dq[i] = 8'($urandom); dma_ack_n = 0; host_wdata = dq[i]; step(); end
    dma_ack_n = 1;
    build_sector(5);
    pull(6, "R7");
    chk(underrun && !drq, "R7", {underrun, drq}, 2);
    for (int i = 0; i < SB - 4; i++) ex[i] = ex[i + 6];
    pull(SB - 4, "R7");
    wait_done("R7");

    // R8: write overrun, buffered bytes replaced by zero fill
    start(1, 1, 0, 4'd15);
    for (int i = 0; i < 17; i++) begin dma_ack_n = 0; host_wdata = 8'hA0 + 8'(i); step(); end
    dma_ack_n = 1;
    chk(overrun, "R8", overrun, 1);
    build_sector(0);
    pull(SB + 2, "R8");
    wait_done("R8");

    // R5 R9: read threshold then overrun, host drains in order
    start(0, 1, 0, 4'd4);
    for (int i = 0; i < 17; i++) begin
      dq[i] = 8'($urandom); dsk_rx_valid = 1; dsk_rx_data = dq[i]; step();
      if (i == 3) chk(!drq, "R5", drq, 0);
      if (i == 4) chk(drq, "R5", drq, 1);
    end
    dsk_rx_valid = 0;
    chk(overrun, "R9", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      chk(drq && host_rdata == dq[i], "R9", host_rdata, dq[i]);
      dma_ack_n = 0; step();
    end
    dma_ack_n = 1;
    wait_done("R9");

    // R4 R6: normal read, two sectors, random pacing, terminal count
    for (int i = 0; i < 2 * SB; i++) dq[i] = 8'($urandom);
    start(0, 1, 0, 4'd3);
    begin
      int ri = 0, hi = 0, n = 0; logic tcd = 0; logic seen = 0;
      while (n < 2000 && !seen) begin
        step();
        dma_ack_n = 1; dsk_rx_valid = 0; term_count = 0;
        if (done) seen = 1;
        else begin
          if (ri < 2 * SB && ($urandom % 2) == 0) begin dsk_rx_valid = 1; dsk_rx_data = dq[ri]; ri++; end
          if (drq) begin
            chk(host_rdata == dq[hi], "R4", host_rdata, dq[hi]);
            dma_ack_n = 0; hi++;
          end
          if (ri == 20 && !tcd) begin term_count = 1; tcd = 1; end
          n++;
        end
      end
      chk(seen && hi == 2 * SB, "R6", hi, 2 * SB);
      chk(!overrun && !underrun, "R4", {overrun, underrun}, 0);
    end
    step();

    // R11 R12: byte mode with verify pseudo-read
    start(0, 0, 1, 4'd0);
    chk(!drq, "R11", drq, 0);
    dsk_rx_valid = 1; dsk_rx_data = 8'h5A; step(); dsk_rx_valid = 0;
    chk(drq, "R11", drq, 1);
    chk(host_rdata == 8'h00, "R12", host_rdata, 0);
    dma_ack_n = 0; step(); dma_ack_n = 1;
    chk(!drq && !overrun && !underrun, "R12", {drq, overrun, underrun}, 0);
    dsk_rx_valid = 1; dsk_rx_data = 8'h11; step();
    dsk_rx_data = 8'h22; step(); dsk_rx_valid = 0;
    chk(overrun, "R11", overrun, 1);
    dma_ack_n = 0; step(); dma_ack_n = 1;
    wait_done("R11");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule